// File: doc/BRIEF.md
# Serial Converter Front-End Emulator

This block is a device-side, bus-functional model of the digital serial port of an eight-input, 12-bit successive-approximation converter. It stands in for the real part when a host controller is being tested. The host drives a serial clock, an active-low select and a data-in line. The block oversamples these lines on its own system clock. It picks up an 8-bit control word that opens with a 1 bit and decodes the channel and the timing mode from it. It then runs an acquisition phase and a conversion phase. The block answers on a strobe line and a serial data-out line, and each of these has its own output-enable. The "converted" value does not come from an analog core. It is the content of a per-channel value register that the test environment loads through a simple write port.

Two timing modes exist. In the local-clock mode, the block times acquisition and conversion itself, with a tick made by dividing the system clock. The strobe is low for the whole sequence, and the result can then be read at any host clock rate. In the host-clock mode, acquisition and conversion are counted in falling edges of the host serial clock. A one-edge strobe pulse comes just before the result bits appear.

Top module: `sadc_emu`

## Requirements
- R1: After reset, dout_oe is 0, the mode is host-clock, strobe is 0, and strobe_oe is 1 only while host_cs_n is low.
- R2: Data-in is sampled on falling edges of host_sclk while host_cs_n is low. Leading 0 bits are ignored. The first 1 bit opens an 8-bit control word that is sent MSB first: bit 7 is that 1, bits 6..4 select the channel, bits 3..2 are ignored, and bits 1..0 select the mode (00 local-clock, 01 host-clock, 10 and 11 no conversion).
- R3: In local-clock mode, strobe goes low once the last control bit is taken. It returns high after 16 local ticks of DIV system clocks each. Acquisition covers the first 4 ticks, and the value is sampled at the end of tick 4.
- R4: In local-clock mode, result bit 11 is on dout when strobe rises. Each later falling host_sclk edge with host_cs_n low presents the next lower bit. After bit 0, dout is 0.
- R5: In host-clock mode, the falling edges after the control word are counted from 1. Strobe is 1 from edge 6 to edge 7 and 0 otherwise. Edges 7 through 18 present result bits 11 down to 0, and edge 19 onward presents 0.
- R6: While host_cs_n is high, dout_oe is 0, no data-in bit is taken, and dout does not shift. A running conversion still completes.
- R7: In local-clock mode strobe_oe stays 1 whatever host_cs_n does. In host-clock mode strobe_oe is 1 only while host_cs_n is low.
- R8: A control word with mode 10 or 11 starts no conversion. Strobe and dout keep their values over the following edges.
- R9: A write with val_we high stores val_data as the value of channel val_ch. A conversion returns the stored value of the channel that its control word selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sclk | input | 1 | Host serial clock, asynchronous |
| host_cs_n | input | 1 | Host select, active low |
| host_din | input | 1 | Host serial data into the block |
| val_we | input | 1 | Channel value write enable |
| val_ch | input | 3 | Channel value write index |
| val_data | input | 12 | Channel value write data |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for dout |
| strobe | output | 1 | Conversion status strobe |
| strobe_oe | output | 1 | Drive enable for strobe |

## Verification
The bench loads three channels with distinct, asymmetric values, so a wrong channel, a bit-order slip or an off-by-one edge count shows up as a bit mismatch. It runs local-clock conversions in three ways: with leading zero bits before the control word, with select held high through the whole conversion while extra clock edges arrive, and again after the channel value has been rewritten. These separate capture gating, shift gating and value selection. A host-clock conversion with the ignored bits set checks the exact edge on which the strobe pulses and the result bits appear. A no-conversion word followed by twenty edges shows that nothing is loaded.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTL,
    ST_IACQ,
    ST_ICONV,
    ST_EACQ,
    ST_ECONV
  } sadc_state_t;

  localparam logic [1:0] MODE_LOCAL = 2'b00;
  localparam logic [1:0] MODE_HOST  = 2'b01;

  // control word field positions (MSB arrives first)
  localparam int CH_HI   = 6;
  localparam int CH_LO   = 4;
  localparam int MODE_HI = 1;
  localparam int MODE_LO = 0;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/sadc_tick.sv
module sadc_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (en) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  // R3
  tick_clr_chk: assert property (@(posedge clk) disable iff (rst) clr |=> !tick);
endmodule

// File: rtl/sadc_value_bank.sv
module sadc_value_bank #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [CHW-1:0] wr_ch,
  input  logic [DW-1:0]  wr_data,
  input  logic [CHW-1:0] rd_ch,
  output logic [DW-1:0]  rd_data
);
  logic [DW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_ch] <= wr_data;
    rd_data <= mem[rd_ch];
  end
endmodule

// File: rtl/sadc_emu.sv
module sadc_emu
  import sadc_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int DW        = 12,
  parameter int CHW       = $clog2(NCH),
  parameter int DIV       = 4,
  parameter int ACQ_TICKS = 4,
  parameter int END_TICKS = 16,
  parameter int EXT_ACQ   = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_sclk,
  input  logic           host_cs_n,
  input  logic           host_din,
  input  logic           val_we,
  input  logic [CHW-1:0] val_ch,
  input  logic [DW-1:0]  val_data,
  output logic           dout,
  output logic           dout_oe,
  output logic           strobe,
  output logic           strobe_oe
);
  localparam logic [4:0] L_ACQ   = 5'(ACQ_TICKS);
  localparam logic [4:0] L_END   = 5'(END_TICKS);
  localparam logic [4:0] L_EACQ  = 5'(EXT_ACQ);
  localparam logic [4:0] L_ELOAD = 5'(EXT_ACQ + 1);
  localparam logic [4:0] L_EEND  = 5'(EXT_ACQ + DW);

  logic [2:0] sync_q;
  logic cs_s, sclk_s, din_s, sclk_d;
  logic fall, cap;

  sadc_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({host_cs_n, host_sclk, host_din}),
    .q(sync_q)
  );
  assign cs_s   = sync_q[2];
  assign sclk_s = sync_q[1];
  assign din_s  = sync_q[0];
  assign fall   = sclk_d & ~sclk_s;
  assign cap    = fall & ~cs_s;

  sadc_state_t    state;
  logic [6:0]     ctl_sr;
  logic [7:0]     ctl_next;
  logic [2:0]     bit_cnt;
  logic           clk_local;
  logic [CHW-1:0] ch_q;
  logic [4:0]     tick_cnt;
  logic [4:0]     fcnt;
  logic [DW-1:0]  sample;
  logic [DW-1:0]  out_sr;
  logic [DW-1:0]  rd_val;
  logic           strb_q, strb_oe_q, dout_oe_q;
  logic           word_done, tick, tick_en;

  assign ctl_next  = {ctl_sr, din_s};
  assign word_done = (state == ST_CTL) && cap && (bit_cnt == 3'd7);
  assign tick_en   = (state == ST_IACQ) || (state == ST_ICONV);

  sadc_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(word_done), .en(tick_en), .tick(tick)
  );

  sadc_value_bank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_bank (
    .clk(clk), .we(val_we), .wr_ch(val_ch), .wr_data(val_data),
    .rd_ch(ch_q), .rd_data(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sclk_d    <= 1'b0;
      ctl_sr    <= '0;
      bit_cnt   <= '0;
      clk_local <= 1'b0;
      ch_q      <= '0;
      tick_cnt  <= '0;
      fcnt      <= '0;
      sample    <= '0;
      out_sr    <= '0;
      strb_q    <= 1'b0;
      strb_oe_q <= 1'b0;
      dout_oe_q <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      dout_oe_q <= ~cs_s;
      strb_oe_q <= clk_local | ~cs_s;
      if (cap) out_sr <= {out_sr[DW-2:0], 1'b0};
      unique case (state)
        ST_IDLE: begin
          if (cap && din_s) begin
            state   <= ST_CTL;
            ctl_sr  <= 7'h01;
            bit_cnt <= 3'd1;
          end
        end
        ST_CTL: begin
          if (cap) begin
            ctl_sr  <= ctl_next[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              ch_q <= CHW'(ctl_next[CH_HI:CH_LO]);
              if (ctl_next[MODE_HI:MODE_LO] == MODE_LOCAL) begin
                clk_local <= 1'b1;
                strb_q    <= 1'b0;
                tick_cnt  <= '0;
                state     <= ST_IACQ;
              end else if (ctl_next[MODE_HI:MODE_LO] == MODE_HOST) begin
                clk_local <= 1'b0;
                strb_q    <= 1'b0;
                fcnt      <= '0;
                state     <= ST_EACQ;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_IACQ: begin
          if (tick) begin
            tick_cnt <= tick_cnt + 5'd1;
            if (tick_cnt + 5'd1 == L_ACQ) begin
              sample <= rd_val;
              state  <= ST_ICONV;
            end
          end
        end
        ST_ICONV: begin
          if (tick) begin
            tick_cnt <= tick_cnt + 5'd1;
            if (tick_cnt + 5'd1 == L_END) begin
              strb_q <= 1'b1;
              out_sr <= sample;
              state  <= ST_IDLE;
            end
          end
        end
        ST_EACQ: begin
          if (fall) begin
            fcnt <= fcnt + 5'd1;
            if (fcnt + 5'd1 == L_EACQ) begin
              strb_q <= 1'b1;
              sample <= rd_val;
              state  <= ST_ECONV;
            end
          end
        end
        ST_ECONV: begin
          if (fall) begin
            fcnt <= fcnt + 5'd1;
            if (fcnt + 5'd1 == L_ELOAD) begin
              strb_q <= 1'b0;
              out_sr <= sample;
            end
            if (fcnt + 5'd1 == L_EEND) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dout      = out_sr[DW-1];
  assign dout_oe   = dout_oe_q;
  assign strobe    = strb_q;
  assign strobe_oe = strb_oe_q;

  // R6
  dout_hiz_chk: assert property (@(posedge clk) disable iff (rst) cs_s |=> !dout_oe);
  // R7
  strobe_drive_chk: assert property (@(posedge clk) disable iff (rst) clk_local |=> strobe_oe);
  // R3
  local_strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IACQ || state == ST_ICONV) |-> !strobe);
  // R3
  tick_bound_chk: assert property (@(posedge clk) disable iff (rst) tick_cnt <= L_END);
  // R5
  host_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(strobe) && !clk_local) |-> (state == ST_ECONV));
  // R2
  ctl_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CTL) |-> (bit_cnt != 3'd0));
endmodule

// File: tb/sim_sadc_emu.sv
module sim_sadc_emu;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam int DIV   = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic host_sclk = 1'b0, host_cs_n = 1'b1, host_din = 1'b0;
  logic val_we = 1'b0;
  logic [2:0] val_ch = '0;
  logic [11:0] val_data = '0;
  logic dout, dout_oe, strobe, strobe_oe;

  sadc_emu #(.DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .host_sclk(host_sclk), .host_cs_n(host_cs_n),
    .host_din(host_din), .val_we(val_we), .val_ch(val_ch), .val_data(val_data),
    .dout(dout), .dout_oe(dout_oe), .strobe(strobe), .strobe_oe(strobe_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic  exp_q[$];
  string tag_q[$];
  event  smp_ev;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic b);
    host_din = b;
    wait_clk(HALF);
    host_sclk = 1'b1;
    wait_clk(HALF);
    host_sclk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_word(logic [7:0] w);
    for (int i = 7; i >= 0; i--) pulse(w[i]);
  endtask

  task automatic set_val(logic [2:0] ch, logic [11:0] v);
    @(negedge clk);
    val_we = 1'b1; val_ch = ch; val_data = v;
    @(negedge clk);
    val_we = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic exp_bit(logic b, string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
    -> smp_ev;
    @(negedge clk);
  endtask

  // monitor side of the scoreboard
  initial forever begin
    @(smp_ev);
    #1;
    if (exp_q.size() == 0) check("scoreboard underrun", 1, 0);
    else begin
      logic e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, int'(dout), int'(e));
    end
  end

  task automatic wait_strobe_high(string req, output int n);
    n = 0;
    while (!strobe && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(req, int'(strobe), 1);
  endtask

  // local-clock readout starting with MSB already present
  task automatic read_local(logic [11:0] v, string req);
    wait_clk(2);
    exp_bit(v[11], req);
    for (int i = 10; i >= 0; i--) begin
      pulse(1'b0);
      exp_bit(v[i], req);
    end
    pulse(1'b0); exp_bit(1'b0, "R4 trailing zero");
    pulse(1'b0); exp_bit(1'b0, "R4 trailing zero");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    int n;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    // R1 reset state, select high
    check("R1 dout_oe", int'(dout_oe), 0);
    check("R1 strobe_oe cs high", int'(strobe_oe), 0);
    set_val(3'd3, 12'hA5C);
    set_val(3'd5, 12'h5A3);
    set_val(3'd1, 12'h3C6);
    set_val(3'd2, 12'hFFF);
    host_cs_n = 1'b0;
    wait_clk(4);
    check("R1 strobe_oe cs low", int'(strobe_oe), 1);
    check("R1 strobe", int'(strobe), 0);
    check("R1 dout", int'(dout), 0);

    // R2 leading zeros then local-clock word, channel 3
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    send_word(8'hB0);
    check("R3 strobe low after word", int'(strobe), 0);
    check("R7 strobe_oe local", int'(strobe_oe), 1);
    wait_strobe_high("R3 strobe returns", n);
    check("R3 conversion length", int'(n >= 16*DIV - 8 && n <= 16*DIV + 2), 1);
    read_local(12'hA5C, "R4 R9 local readout ch3");

    // R6 select high through a local-clock conversion, channel 5
    send_word(8'hD0);
    host_cs_n = 1'b1;
    wait_clk(4);
    check("R6 dout_oe off", int'(dout_oe), 0);
    check("R7 strobe_oe kept", int'(strobe_oe), 1);
    check("R3 strobe low", int'(strobe), 0);
    pulse(1'b1); pulse(1'b1); pulse(1'b1); pulse(1'b1);
    wait_strobe_high("R6 conversion completes", n);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    host_cs_n = 1'b0;
    wait_clk(4);
    check("R6 dout_oe on", int'(dout_oe), 1);
    read_local(12'h5A3, "R6 R9 no shift while deselected ch5");

    // R5 host-clock word, channel 1, ignored bits set
    send_word(8'h9D);
    check("R7 strobe_oe host cs low", int'(strobe_oe), 1);
    for (int k = 1; k <= 20; k++) begin
      pulse(1'b0);
      if (k == 6) check("R5 strobe pulse", int'(strobe), 1);
      else check("R5 strobe low", int'(strobe), 0);
      if (k >= 7 && k <= 18) exp_bit(12'h3C6 >> (18 - k), "R5 host result bit");
      else if (k > 18) exp_bit(1'b0, "R5 trailing zero");
    end
    host_cs_n = 1'b1;
    wait_clk(4);
    check("R7 strobe_oe host cs high", int'(strobe_oe), 0);
    check("R6 dout_oe host cs high", int'(dout_oe), 0);
    host_cs_n = 1'b0;
    wait_clk(4);

    // R8 no-conversion word, channel 2
    send_word(8'hA2);
    for (int k = 1; k <= 20; k++) begin
      pulse(1'b0);
      check("R8 strobe unchanged", int'(strobe), 0);
      exp_bit(1'b0, "R8 dout unchanged");
    end

    // R9 rewrite channel 3 and convert again
    set_val(3'd3, 12'h123);
    send_word(8'hB0);
    wait_strobe_high("R9 strobe returns", n);
    read_local(12'h123, "R9 rewritten ch3");

    wait_clk(10);
    finish_run();
  end
endmodule